// File: doc/BRIEF.md
# Private Peripheral Window Decoder

This block sits at the entry of a 1 MB private system address window and decides, for every request, which sub-region serves it. A request carries a 20-bit byte offset, a read/write flag, a secure flag and a privilege flag. The decoder steers the request to the system register space, to one of two tick-timer banks picked by the security flag, or to its own local responder, which answers for unmapped space, for the optional error-reporting block and for non-secure use of the optional non-secure alias.

Region choice is by priority: the tick-timer range inside the system space wins over the system space, which wins over the default region. Secure requests that arrive through the alias window are forwarded to the system space (or the non-secure tick bank) with the security attribute cleared. Target selection and the forwarded offset and attribute are combinational; the local responder answers one clock after the request with a registered read-data and error response. The system space is further classified into sub-ranges so that the register blocks behind it need no decode of their own.

The alias window and the error-reporting block are each enabled by an elaboration parameter.

Top module: `ppb_decoder`

## Requirements
- R1: While req_valid_i is high exactly one bit of sel_o is set (bit 0 system space, bit 1 secure tick bank, bit 2 non-secure tick bank, bit 3 local responder); while it is low sel_o is zero.
- R2: Offsets 0xE000 to 0xEFFF outside the tick range select bit 0, with fwd_addr_o equal to offset bits 11:0 and fwd_secure_o equal to req_secure_i.
- R3: Offsets 0xE010 to 0xE0EF select bit 1 when req_secure_i is high and bit 2 when it is low, with fwd_addr_o equal to offset bits 11:0 and fwd_secure_o equal to req_secure_i; this range takes precedence over the system space.
- R4: A local request with req_priv_i high gets rsp_valid_o high and rsp_err_o low on the next clock, with rsp_rdata_o zero unless R8 says otherwise; writes change nothing. Without a local request in the previous cycle, rsp_valid_o, rsp_err_o and rsp_rdata_o are zero.
- R5: A local request with req_priv_i low gets rsp_valid_o and rsp_err_o high and rsp_rdata_o zero on the next clock.
- R6: A secure request at 0x2E000 to 0x2EFFF is forwarded with fwd_secure_o low and fwd_addr_o equal to offset bits 11:0, to bit 2 if those bits lie in 0x010 to 0x0EF and to bit 0 otherwise.
- R7: A non-secure request at 0x2E000 to 0x2EFFF selects bit 3 and is answered as in R4 or R5.
- R8: Requests at 0x5000 to 0x5FFF select bit 3; a privileged read of offset 0x5E10 returns 0x43B, every other privileged access returns zero (including 0x5FC8), and user requests fault as in R5.
- R9: When bit 0 of sel_o is set, sys_sub_o gives 1 for fwd_addr_o 0x004 to 0x007, 2 for 0x100 to 0x7EF, 3 for 0xD00 to 0xD3F, 4 for 0xF00 to 0xF03 and 0 elsewhere; when bit 0 is clear it is 0.
- R10: During reset rsp_valid_o, rsp_err_o and rsp_rdata_o are zero; fwd_addr_o and fwd_secure_o are zero whenever bit 3 of sel_o is set or no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the local response register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | 20 | Byte offset in the window |
| req_write_i | input | 1 | 1 write, 0 read |
| req_secure_i | input | 1 | Secure attribute of the request |
| req_priv_i | input | 1 | 1 privileged, 0 user |
| sel_o | output | 4 | One-hot target select |
| fwd_addr_o | output | 12 | Offset within the forwarded 4 KB region |
| fwd_secure_o | output | 1 | Security attribute after rewrite |
| sys_sub_o | output | 3 | Sub-range code inside the system space |
| rsp_valid_o | output | 1 | Local response valid |
| rsp_err_o | output | 1 | Local response is a bus error |
| rsp_rdata_o | output | 32 | Local response read data |

## Verification
The assertions assume that req_addr_i, req_write_i, req_secure_i and req_priv_i are stable while req_valid_i is high across a clock edge, and that no X reaches them after reset; the stimulus changes inputs only on the falling edge and holds them for a whole cycle. They also take the default base offsets, so the alias-window checks are only meaningful with the alias enabled. The stimulus mixes directed offsets at every region edge (first and last byte of each range, one byte outside) with random offsets biased towards the mapped regions, in all four combinations of the secure and privilege flags, reads and writes, and idle cycles between requests.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  localparam int unsigned TGT_N = 4;

  typedef enum logic [1:0] {
    TGT_SYS     = 2'd0,
    TGT_TICK_S  = 2'd1,
    TGT_TICK_NS = 2'd2,
    TGT_LOCAL   = 2'd3
  } tgt_e;

  typedef enum logic [2:0] {
    SUB_NONE   = 3'd0,
    SUB_CTYPE  = 3'd1,
    SUB_INTC   = 3'd2,
    SUB_CTRL   = 3'd3,
    SUB_SWTRIG = 3'd4
  } sub_e;

  localparam logic [11:0] CTYPE_LO  = 12'h004;
  localparam logic [11:0] CTYPE_HI  = 12'h007;
  localparam logic [11:0] INTC_LO   = 12'h100;
  localparam logic [11:0] INTC_HI   = 12'h7EF;
  localparam logic [11:0] CTRL_LO   = 12'hD00;
  localparam logic [11:0] CTRL_HI   = 12'hD3F;
  localparam logic [11:0] SWTRIG_LO = 12'hF00;
  localparam logic [11:0] SWTRIG_HI = 12'hF03;
endpackage

// File: rtl/ppb_window_match.sv
module ppb_window_match #(
  parameter int unsigned    AW      = 20,
  parameter int unsigned    SPAN_AW = 12,
  parameter logic [AW-1:0]  BASE    = '0,
  parameter bit             EN      = 1'b1
) (
  input  logic [AW-1:0]      addr_i,
  output logic               hit_o,
  output logic [SPAN_AW-1:0] off_o
);
  assign off_o = addr_i[SPAN_AW-1:0];

  generate
    if (EN) begin : g_on
      assign hit_o = (addr_i[AW-1:SPAN_AW] == BASE[AW-1:SPAN_AW]);
    end else begin : g_off
      assign hit_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ppb_sys_subdec.sv
module ppb_sys_subdec
  import ppb_pkg::*;
#(
  parameter int unsigned OW = 12
) (
  input  logic [OW-1:0] off_i,
  output logic [2:0]    sub_o
);
  always_comb begin
    sub_o = SUB_NONE;
    if (off_i >= CTYPE_LO && off_i <= CTYPE_HI)        sub_o = SUB_CTYPE;
    else if (off_i >= INTC_LO && off_i <= INTC_HI)     sub_o = SUB_INTC;
    else if (off_i >= CTRL_LO && off_i <= CTRL_HI)     sub_o = SUB_CTRL;
    else if (off_i >= SWTRIG_LO && off_i <= SWTRIG_HI) sub_o = SUB_SWTRIG;
  end
endmodule

// File: rtl/ppb_local_rsp.sv
module ppb_local_rsp #(
  parameter int unsigned   DW     = 32,
  parameter logic [DW-1:0] ID_VAL = 32'h0000_043B
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          priv_i,
  input  logic          id_hit_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [DW-1:0] rsp_rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= fire_i;
      rsp_err_o   <= fire_i & ~priv_i;
      rsp_rdata_o <= (fire_i && priv_i && id_hit_i) ? ID_VAL : '0;
    end
  end
endmodule

// File: rtl/ppb_decoder.sv
module ppb_decoder
  import ppb_pkg::*;
#(
  parameter int unsigned   AW         = 20,
  parameter int unsigned   RW         = 12,
  parameter int unsigned   DW         = 32,
  parameter logic [AW-1:0] SYS_BASE   = 20'h0E000,
  parameter logic [AW-1:0] ALIAS_BASE = 20'h2E000,
  parameter logic [AW-1:0] ERR_BASE   = 20'h05000,
  parameter logic [RW-1:0] TICK_LO    = 12'h010,
  parameter logic [RW-1:0] TICK_HI    = 12'h0EF,
  parameter logic [RW-1:0] ID_OFF     = 12'hE10,
  parameter logic [DW-1:0] ID_VAL     = 32'h0000_043B,
  parameter bit            ALIAS_EN   = 1'b1,
  parameter bit            ERRBLK_EN  = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic            req_write_i,
  input  logic            req_secure_i,
  input  logic            req_priv_i,
  output logic [TGT_N-1:0] sel_o,
  output logic [RW-1:0]   fwd_addr_o,
  output logic            fwd_secure_o,
  output logic [2:0]      sys_sub_o,
  output logic            rsp_valid_o,
  output logic            rsp_err_o,
  output logic [DW-1:0]   rsp_rdata_o
);
  logic          sys_hit, alias_hit, err_hit;
  logic [RW-1:0] sys_off, alias_off, err_off;
  logic          sys_in_tick, alias_in_tick, id_hit;
  logic [2:0]    sub_raw;

  ppb_window_match #(.AW(AW), .SPAN_AW(RW), .BASE(SYS_BASE), .EN(1'b1)) u_sys_win (
    .addr_i(req_addr_i), .hit_o(sys_hit), .off_o(sys_off)
  );
  ppb_window_match #(.AW(AW), .SPAN_AW(RW), .BASE(ALIAS_BASE), .EN(ALIAS_EN)) u_alias_win (
    .addr_i(req_addr_i), .hit_o(alias_hit), .off_o(alias_off)
  );
  ppb_window_match #(.AW(AW), .SPAN_AW(RW), .BASE(ERR_BASE), .EN(ERRBLK_EN)) u_err_win (
    .addr_i(req_addr_i), .hit_o(err_hit), .off_o(err_off)
  );

  assign sys_in_tick   = (sys_off >= TICK_LO) && (sys_off <= TICK_HI);
  assign alias_in_tick = (alias_off >= TICK_LO) && (alias_off <= TICK_HI);

  // priority: tick > system > secure alias > local (default, error block, NS alias)
  always_comb begin
    sel_o        = '0;
    fwd_addr_o   = '0;
    fwd_secure_o = 1'b0;
    if (req_valid_i) begin
      if (sys_hit) begin
        fwd_addr_o   = sys_off;
        fwd_secure_o = req_secure_i;
        if (sys_in_tick) sel_o[req_secure_i ? TGT_TICK_S : TGT_TICK_NS] = 1'b1;
        else             sel_o[TGT_SYS] = 1'b1;
      end else if (alias_hit && req_secure_i) begin
        fwd_addr_o = alias_off;
        if (alias_in_tick) sel_o[TGT_TICK_NS] = 1'b1;
        else               sel_o[TGT_SYS] = 1'b1;
      end else begin
        sel_o[TGT_LOCAL] = 1'b1;
      end
    end
  end

  ppb_sys_subdec #(.OW(RW)) u_subdec (.off_i(fwd_addr_o), .sub_o(sub_raw));
  assign sys_sub_o = sel_o[TGT_SYS] ? sub_raw : SUB_NONE;

  assign id_hit = err_hit && (err_off == ID_OFF) && !req_write_i;

  ppb_local_rsp #(.DW(DW), .ID_VAL(ID_VAL)) u_local (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (sel_o[TGT_LOCAL]),
    .priv_i      (req_priv_i),
    .id_hit_i    (id_hit),
    .rsp_valid_o (rsp_valid_o),
    .rsp_err_o   (rsp_err_o),
    .rsp_rdata_o (rsp_rdata_o)
  );
endmodule

// File: rtl/ppb_decoder_chk.sv
module ppb_decoder_chk #(
  parameter int unsigned   AW         = 20,
  parameter int unsigned   RW         = 12,
  parameter int unsigned   DW         = 32,
  parameter logic [AW-1:0] ALIAS_BASE = 20'h2E000,
  parameter bit            ALIAS_EN   = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [AW-1:0] req_addr_i,
  input logic          req_secure_i,
  input logic          req_priv_i,
  input logic [3:0]    sel_o,
  input logic          fwd_secure_o,
  input logic [2:0]    sys_sub_o,
  input logic          rsp_valid_o,
  input logic          rsp_err_o,
  input logic [DW-1:0] rsp_rdata_o
);
  logic in_alias;
  assign in_alias = ALIAS_EN && (req_addr_i[AW-1:RW] == ALIAS_BASE[AW-1:RW]);

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $onehot(sel_o)); // R1
  AST_IDLE_NOSEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (sel_o == 4'b0)); // R1
  AST_TICK_S_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && sel_o[1]) |-> (req_secure_i && fwd_secure_o)); // R3
  AST_PRIV_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && sel_o[3] && req_priv_i) |=> (rsp_valid_o && !rsp_err_o)); // R4
  AST_NO_STRAY_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && sel_o[3]) |=> (!rsp_valid_o && !rsp_err_o && rsp_rdata_o == '0)); // R4
  AST_USER_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && sel_o[3] && !req_priv_i) |=> (rsp_valid_o && rsp_err_o && rsp_rdata_o == '0)); // R5
  AST_ALIAS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && in_alias && req_secure_i) |-> (!fwd_secure_o && !sel_o[3] && !sel_o[1])); // R6
  AST_ALIAS_NS_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && in_alias && !req_secure_i) |-> sel_o[3]); // R7
  AST_SUB_ONLY_SYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_sub_o != 3'd0) |-> sel_o[0]); // R9
endmodule

bind ppb_decoder ppb_decoder_chk #(
  .AW(AW), .RW(RW), .DW(DW), .ALIAS_BASE(ALIAS_BASE), .ALIAS_EN(ALIAS_EN)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_addr_i   (req_addr_i),
  .req_secure_i (req_secure_i),
  .req_priv_i   (req_priv_i),
  .sel_o        (sel_o),
  .fwd_secure_o (fwd_secure_o),
  .sys_sub_o    (sys_sub_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_err_o    (rsp_err_o),
  .rsp_rdata_o  (rsp_rdata_o)
);

// File: tb/ppb_decoder_test.sv
`timescale 1ns/1ps
module ppb_decoder_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [19:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic        req_secure_i = 1'b0;
  logic        req_priv_i = 1'b0;
  logic [3:0]  sel_o;
  logic [11:0] fwd_addr_o;
  logic        fwd_secure_o;
  logic [2:0]  sys_sub_o;
  logic        rsp_valid_o;
  logic        rsp_err_o;
  logic [31:0] rsp_rdata_o;

  int compared = 0;
  int mismatched = 0;

  always #2 clk_i = ~clk_i;

  ppb_decoder uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
    .req_write_i(req_write_i), .req_secure_i(req_secure_i), .req_priv_i(req_priv_i),
    .sel_o(sel_o), .fwd_addr_o(fwd_addr_o), .fwd_secure_o(fwd_secure_o),
    .sys_sub_o(sys_sub_o), .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o),
    .rsp_rdata_o(rsp_rdata_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s addr=%h actual=%h expected=%h", tag, what, req_addr_i, act, exp);
    end
  endtask

  // behavioural model of the requirements
  int  m_sel, m_fwd, m_fsec, m_sub, m_lerr, m_ldata;
  bit  m_local;
  string m_tag;

  function automatic int sub_of(int off);
    if (off >= 'h004 && off <= 'h007) return 1;
    if (off >= 'h100 && off <= 'h7EF) return 2;
    if (off >= 'hD00 && off <= 'hD3F) return 3;
    if (off >= 'hF00 && off <= 'hF03) return 4;
    return 0;
  endfunction

  task automatic model(input bit v, input int a, input bit w, input bit s, input bit p);
    m_sel = 0; m_fwd = 0; m_fsec = 0; m_sub = 0; m_local = 0; m_lerr = 0; m_ldata = 0;
    m_tag = "R1";
    if (!v) return;
    if (a >= 'hE010 && a <= 'hE0EF) begin
      m_sel = s ? 2 : 4; m_fwd = a & 'hFFF; m_fsec = s; m_tag = "R3";
    end else if (a >= 'hE000 && a <= 'hEFFF) begin
      m_sel = 1; m_fwd = a & 'hFFF; m_fsec = s; m_tag = "R2";
    end else if (a >= 'h2E000 && a <= 'h2EFFF) begin
      if (s) begin
        m_fwd = a & 'hFFF; m_fsec = 0; m_tag = "R6";
        m_sel = (m_fwd >= 'h010 && m_fwd <= 'h0EF) ? 4 : 1;
      end else begin
        m_local = 1; m_tag = "R7";
      end
    end else if (a >= 'h5000 && a <= 'h5FFF) begin
      m_local = 1; m_tag = "R8";
      if (p && !w && a == 'h5E10) m_ldata = 'h43B;
    end else begin
      m_local = 1; m_tag = p ? "R4" : "R5";
    end
    if (m_local) begin
      m_sel = 8; m_lerr = !p;
    end
    if (m_sel == 1) m_sub = sub_of(m_fwd);
  endtask

  task automatic issue(input bit v, input int a, input bit w, input bit s, input bit p);
    bit    e_lv;
    int    e_le, e_ld;
    string t;
    @(negedge clk_i);
    req_valid_i = v; req_addr_i = a[19:0]; req_write_i = w;
    req_secure_i = s; req_priv_i = p;
    model(v, a, w, s, p);
    #1;
    chk(m_tag, "sel", {28'b0, sel_o}, m_sel);
    chk(m_tag, "fwd_addr", {20'b0, fwd_addr_o}, m_fwd);
    chk(m_tag, "fwd_secure", {31'b0, fwd_secure_o}, m_fsec);
    chk(m_sel == 1 ? "R9" : m_tag, "sub", {29'b0, sys_sub_o}, m_sub);
    e_lv = m_local; e_le = m_lerr; e_ld = m_ldata; t = m_tag;
    if (!m_local) t = "R4";
    @(posedge clk_i);
    #1;
    chk(t, "rsp_valid", {31'b0, rsp_valid_o}, e_lv);
    chk(t, "rsp_err", {31'b0, rsp_err_o}, e_le);
    chk(t, "rsp_rdata", rsp_rdata_o, e_ld);
  endtask

  initial begin
    #(4 * 190000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R10", "reset rsp_valid", {31'b0, rsp_valid_o}, 0);
    chk("R10", "reset rsp_err", {31'b0, rsp_err_o}, 0);
    chk("R10", "reset rsp_rdata", rsp_rdata_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // directed edges
    issue(0, 'hE100, 0, 1, 1);                       // R1 idle
    issue(1, 'hE000, 0, 1, 1);                       // R2
    issue(1, 'hE004, 0, 0, 0);                       // R9 ctype
    issue(1, 'hE00F, 1, 1, 1);                       // R2 just below tick
    issue(1, 'hE010, 0, 1, 1);                       // R3 secure bank
    issue(1, 'hE010, 0, 0, 1);                       // R3 ns bank
    issue(1, 'hE0EF, 1, 0, 0);                       // R3 top
    issue(1, 'hE0F0, 0, 1, 0);                       // R2 just above tick
    issue(1, 'hE7EF, 0, 1, 1);                       // R9 intc top
    issue(1, 'hE7F0, 0, 1, 1);                       // R9 reserved
    issue(1, 'hED3C, 0, 1, 1);                       // R9 ctrl
    issue(1, 'hEF00, 1, 0, 1);                       // R9 sw trigger
    issue(1, 'hEFFF, 0, 1, 1);                       // R2 top
    issue(1, 'hF000, 0, 1, 1);                       // R4 default privileged
    issue(1, 'hDFFF, 1, 1, 0);                       // R5 default user
    issue(1, 'h00000, 0, 0, 1);                      // R4
    issue(1, 'hFFFFF, 0, 0, 0);                      // R5
    issue(1, 'h2E000, 0, 1, 1);                      // R6 alias sys
    issue(1, 'h2E010, 0, 1, 0);                      // R6 alias tick
    issue(1, 'h2EF00, 1, 1, 1);                      // R6 sw trigger via alias
    issue(1, 'h2E010, 0, 0, 1);                      // R7 ns privileged
    issue(1, 'h2EFFF, 1, 0, 0);                      // R7 ns user
    issue(1, 'h2F000, 0, 1, 1);                      // R4 past alias
    issue(1, 'h5E10, 0, 0, 1);                       // R8 id value
    issue(1, 'h5E10, 1, 1, 1);                       // R8 write ignored
    issue(1, 'h5E10, 0, 1, 1);                       // R8 read after write
    issue(1, 'h5FC8, 0, 1, 1);                       // R8 zero
    issue(1, 'h5E10, 0, 1, 0);                       // R8 user fault
    issue(1, 'h5000, 1, 0, 1);                       // R8 low edge
    issue(0, 'h5E10, 0, 1, 1);                       // R1 idle after local

    // random mix biased to mapped regions
    for (int i = 0; i < 3000; i++) begin
      int a;
      int k = $urandom % 8;
      int lo = $urandom % 4096;
      case (k)
        0, 1: a = 'hE000 + lo;
        2:    a = 'hE000 + ($urandom % 256);
        3, 4: a = 'h2E000 + lo;
        5:    a = 'h5000 + (($urandom % 2) ? 'hE10 : lo);
        default: a = $urandom % 'h100000;
      endcase
      issue(($urandom % 6) != 0, a, $urandom % 2, $urandom % 2, $urandom % 2);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule